// File: doc/BRIEF.md
# Pointer-Addressed Register Slave on a Two-Wire Serial Bus

This block is a target on a two-wire serial bus (I2C/SMBus signalling, 7-bit addressing). It runs entirely in the system clock domain. It oversamples the clock and data lines through a synchronizer and a glitch filter, detects start, repeated start and stop conditions, and answers only on its own address. The lowest address bit is set by the `addr_sel` pin. SDA is driven through an open-drain enable: a high `sda_oe` pulls the line low.

A controller reaches a bank of byte-wide control registers through an 8-bit index pointer. A write transfer first loads the pointer and then stores data bytes at consecutive indices. A read transfer returns bytes from the pointer onwards. The pointer keeps its value across stops and repeated starts, so a short write that only sets the pointer can be followed by a separate read. The whole bank is also presented in parallel on `regs_o` for use by the rest of the chip. No streaming interface exists at the block's edge, so no valid/ready back-pressure rules apply: the serial bus does its own pacing, one bit per SCL period.

Top module: `i2c_ptr_regslave`

## Requirements
- R1: After reset `sda_oe` is 0 and every byte of `regs_o` is 0x00.
- R2: The first byte after a start holds a 7-bit address (bit 7 down to bit 1) and a direction bit (bit 0, 1 = read). The address is `{ADDR_HI, addr_sel}`. On a match the slave pulls SDA low for the 9th SCL period. On a mismatch it never drives SDA and nothing it holds changes until the next start.
- R3: In a write transfer the byte after the address loads the pointer. Each later byte, sent MSB first, is stored at the pointer index and acknowledged, and the pointer then increments.
- R4: In a read transfer the slave sends the byte at the pointer, MSB first, and increments the pointer after each byte. The pointer value survives stops and repeated starts.
- R5: During a read, SDA high on the 9th clock (controller NACK) ends the data. The slave keeps SDA released until the next start. A stop always releases SDA.
- R6: A start seen at any point, including in the middle of a byte, restarts address decoding.
- R7: Index 0x0F is reserved. A data write while the pointer holds 0x0F is not acknowledged, is not stored, and ends the transfer. A read address while the pointer holds 0x0F is not acknowledged. A sequential read that reaches 0x0F releases SDA, so the controller reads 0xFF. Register 0x0F always reads 0x00 on `regs_o`.
- R8: Indices 16 to 255 lie outside the bank. Writes to them are acknowledged but dropped, and reads from them return 0x00. The pointer wraps from 0xFF to 0x00.
- R9: An SCL high pulse shorter than `FILT_LEN` system clocks is ignored.
- R10: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_sel | input | 1 | Sets the lowest bit of the slave address |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| regs_o | output | NREG*8 | Parallel view of the register bank; register i sits at bits i*8+7:i*8 |

## Verification
The bench builds the block with `ADDR_HI = 6'b011010` and `FILT_LEN = 4`, and leaves `NREG = 16` and `RSVD_IDX = 15` at their defaults. The non-default address lets the tests drive `addr_sel` both ways, giving slave addresses 0x35 and 0x34, and send a mismatching address. The longer filter lets a 3-clock SCL glitch fall just short of the acceptance threshold, which tests the filter at its boundary. The 16-entry bank keeps the reserved index inside the bank, and it lets pointer values 0xFE and 0xFF exercise the out-of-range drop and the wrap back to register 0.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_DEC, ST_ACK, ST_TX, ST_MACK, ST_NEXT, ST_SKIP
  } slv_state_t;

  typedef enum logic [1:0] {
    PH_ADDR, PH_PTR, PH_DATA
  } rx_phase_t;
endpackage

// File: rtl/i2cs_line_filter.sv
module i2cs_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic          s1, s2;
  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1     <= 1'b1;
      s2     <= 1'b1;
      filt_o <= 1'b1;
      run    <= '0;
    end else begin
      s1 <= raw_i;
      s2 <= s1;
      if (s2 != filt_o) begin
        if (run == CW'(FILT_LEN - 1)) begin
          filt_o <= s2;
          run    <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end else begin
        run <= '0;
      end
    end
  end
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/i2cs_regbank.sv
module i2cs_regbank #(
  parameter int NREG = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      wr_idx,
  input  logic [7:0]      wr_data,
  input  logic [7:0]      rd_idx,
  output logic [7:0]      rd_data,
  output logic [NREG*8-1:0] regs_o
);
  localparam int         IW     = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [7:0] NREG_B = 8'(NREG);

  logic [7:0] mem [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= 8'h00;
    end else if (wr_en && (wr_idx < NREG_B)) begin
      mem[wr_idx[IW-1:0]] <= wr_data;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_idx < NREG_B) rd_data = mem[rd_idx[IW-1:0]];
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_o[g*8 +: 8] = mem[g];
  end
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter logic [5:0] ADDR_HI  = 6'b100110,
  parameter int         NREG     = 16,
  parameter logic [7:0] RSVD_IDX = 8'h0F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_f,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       addr_sel,
  input  logic [7:0] rd_data,
  output logic [7:0] rd_idx,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic       sda_oe
);
  localparam logic [7:0] NREG_B = 8'(NREG);

  slv_state_t state;
  rx_phase_t  phase;
  logic [3:0] bcnt;
  logic [7:0] shreg;
  logic [7:0] ptr;
  logic       ack_ok;
  logic       rd_mode;
  logic [7:0] rx_byte;
  logic [6:0] my_addr;

  assign rx_byte = {shreg[6:0], sda_f};
  assign my_addr = {ADDR_HI, addr_sel};
  assign rd_idx  = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      phase   <= PH_ADDR;
      bcnt    <= '0;
      shreg   <= '0;
      ptr     <= '0;
      ack_ok  <= 1'b0;
      rd_mode <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state  <= ST_RX;
        phase  <= PH_ADDR;
        bcnt   <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_RX: if (scl_rise) begin
            shreg <= rx_byte;
            if (bcnt == 4'd7) begin
              bcnt  <= '0;
              state <= ST_DEC;
              case (phase)
                PH_ADDR: begin
                  rd_mode <= rx_byte[0];
                  ack_ok  <= (rx_byte[7:1] == my_addr) &&
                             !(rx_byte[0] && (ptr == RSVD_IDX));
                  phase   <= PH_PTR;
                end
                PH_PTR: begin
                  ack_ok <= 1'b1;
                  ptr    <= rx_byte;
                  phase  <= PH_DATA;
                end
                default: begin
                  if (ptr == RSVD_IDX) begin
                    ack_ok <= 1'b0;
                  end else begin
                    ack_ok  <= 1'b1;
                    wr_en   <= (ptr < NREG_B);
                    wr_idx  <= ptr;
                    wr_data <= rx_byte;
                    ptr     <= ptr + 8'd1;
                  end
                end
              endcase
            end else begin
              bcnt <= bcnt + 4'd1;
            end
          end
          ST_DEC: if (scl_fall) begin
            sda_oe <= ack_ok;
            state  <= ST_ACK;
          end
          ST_ACK: if (scl_fall) begin
            if (!ack_ok) begin
              sda_oe <= 1'b0;
              state  <= ST_SKIP;
            end else if (rd_mode) begin
              if (ptr == RSVD_IDX) begin
                sda_oe <= 1'b0;
                state  <= ST_SKIP;
              end else begin
                sda_oe <= ~rd_data[7];
                shreg  <= {rd_data[6:0], 1'b0};
                bcnt   <= '0;
                state  <= ST_TX;
              end
            end else begin
              sda_oe <= 1'b0;
              bcnt   <= '0;
              state  <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bcnt <= bcnt + 4'd1;
            end else if (scl_fall) begin
              if (bcnt == 4'd8) begin
                sda_oe <= 1'b0;
                state  <= ST_MACK;
              end else begin
                sda_oe <= ~shreg[7];
                shreg  <= {shreg[6:0], 1'b0};
              end
            end
          end
          ST_MACK: if (scl_rise) begin
            ptr   <= ptr + 8'd1;
            state <= sda_f ? ST_SKIP : ST_NEXT;
          end
          ST_NEXT: if (scl_fall) begin
            if (ptr == RSVD_IDX) begin
              sda_oe <= 1'b0;
              state  <= ST_SKIP;
            end else begin
              sda_oe <= ~rd_data[7];
              shreg  <= {rd_data[6:0], 1'b0};
              bcnt   <= '0;
              state  <= ST_TX;
            end
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_ptr_regslave.sv
module i2c_ptr_regslave #(
  parameter logic [5:0] ADDR_HI  = 6'b100110,
  parameter int         NREG     = 16,
  parameter logic [7:0] RSVD_IDX = 8'h0F,
  parameter int         FILT_LEN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel,
  output logic              sda_oe,
  output logic [NREG*8-1:0] regs_o
);
  logic [1:0] raw_lines;
  logic [1:0] filt_lines;
  logic       scl_f, sda_f;
  logic       scl_rise, scl_fall, start_det, stop_det;
  logic       wr_en;
  logic [7:0] wr_idx, wr_data, rd_idx, rd_data;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2cs_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (raw_lines[g]),
      .filt_o (filt_lines[g])
    );
  end

  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  i2cs_bus_events u_events (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_f     (scl_f),
    .sda_f     (sda_f),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2cs_engine #(
    .ADDR_HI  (ADDR_HI),
    .NREG     (NREG),
    .RSVD_IDX (RSVD_IDX)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_f     (sda_f),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .addr_sel  (addr_sel),
    .rd_data   (rd_data),
    .rd_idx    (rd_idx),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .sda_oe    (sda_oe)
  );

  i2cs_regbank #(.NREG(NREG)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .regs_o  (regs_o)
  );
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker #(
  parameter int         NREG     = 16,
  parameter logic [7:0] RSVD_IDX = 8'h0F
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_f,
  input logic              sda_oe,
  input logic              start_det,
  input logic              stop_det,
  input logic              wr_en,
  input logic [7:0]        wr_idx,
  input logic [NREG*8-1:0] regs_o
);
  assert_oe_rise_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);

  assert_oe_steady_scl_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && $past(scl_f)) |-> $stable(sda_oe));

  assert_stop_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  assert_start_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  assert_no_reserved_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx != RSVD_IDX));

  if (int'(RSVD_IDX) < NREG) begin : g_rsvd
    assert_reserved_reg_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      regs_o[int'(RSVD_IDX)*8 +: 8] == 8'h00);
  end
endmodule

bind i2c_ptr_regslave i2cs_checker #(
  .NREG     (NREG),
  .RSVD_IDX (RSVD_IDX)
) u_i2cs_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_f     (scl_f),
  .sda_oe    (sda_oe),
  .start_det (start_det),
  .stop_det  (stop_det),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .regs_o    (regs_o)
);

// File: tb/test_i2c_ptr_regslave.sv
`timescale 1ns/1ps
module test_i2c_ptr_regslave;
  localparam logic [5:0] ADDR_HI = 6'b011010;
  localparam int NREG = 16;
  localparam int FILT = 4;
  localparam int HP   = 20;
  localparam logic [7:0] AW1 = {ADDR_HI, 1'b1, 1'b0};
  localparam logic [7:0] AR1 = {ADDR_HI, 1'b1, 1'b1};
  localparam logic [7:0] AW0 = {ADDR_HI, 1'b0, 1'b0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1;
  logic sda_drv = 1'b1;
  logic addr_sel = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [NREG*8-1:0] regs_o;

  int checks = 0;
  int errs = 0;
  int r10_viol = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  logic [7:0] obs_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;
  assign sda_line = sda_drv & ~sda_oe;

  i2c_ptr_regslave #(.ADDR_HI(ADDR_HI), .NREG(NREG), .FILT_LEN(FILT)) i_i2c_ptr_regslave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
    .addr_sel(addr_sel), .sda_oe(sda_oe), .regs_o(regs_o));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // monitor: pops observed bus results against scoreboard expectations
  initial forever begin
    @(negedge clk);
    while (obs_q.size() > 0 && exp_q.size() > 0)
      check(tag_q.pop_front(), obs_q.pop_front(), exp_q.pop_front());
  end

  // R10 watcher: SDA drive must not move while SCL is held high
  logic prev_oe = 1'b0, prev_scl = 1'b1;
  always @(negedge clk) begin
    if (rst_n && scl_drv && prev_scl && (sda_oe != prev_oe)) r10_viol++;
    prev_oe  <= sda_oe;
    prev_scl <= scl_drv;
  end

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    sda_drv = 1'b1; wt(HP); scl_drv = 1'b1; wt(HP);
    sda_drv = 1'b0; wt(HP); scl_drv = 1'b0; wt(HP);
  endtask

  task automatic bus_stop;
    sda_drv = 1'b0; wt(HP); scl_drv = 1'b1; wt(HP); sda_drv = 1'b1; wt(HP);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, input bit glitch);
    for (int i = 7; i > 7 - n; i--) begin
      sda_drv = b[i]; wt(HP / 2);
      if (glitch) begin scl_drv = 1'b1; wt(FILT - 1); scl_drv = 1'b0; end
      wt(HP / 2); scl_drv = 1'b1; wt(HP); scl_drv = 1'b0;
    end
  endtask

  // sends a byte, pushes expected ack (1 = acknowledged) and the observed ack
  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req,
                           input bit glitch = 1'b0);
    logic ack;
    send_bits(b, 8, glitch);
    sda_drv = 1'b1; wt(HP); scl_drv = 1'b1; wt(HP / 2);
    ack = ~sda_line; wt(HP / 2); scl_drv = 1'b0;
    exp_q.push_back({7'd0, exp_ack}); tag_q.push_back(req); obs_q.push_back({7'd0, ack});
  endtask

  task automatic recv_byte(input logic [7:0] exp, input bit m_ack, input string req);
    logic [7:0] d;
    sda_drv = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(HP); scl_drv = 1'b1; wt(HP / 2); d[i] = sda_line; wt(HP / 2); scl_drv = 1'b0;
    end
    sda_drv = ~m_ack; wt(HP); scl_drv = 1'b1; wt(HP); scl_drv = 1'b0; wt(1); sda_drv = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(req); obs_q.push_back(d);
  endtask

  function automatic logic [7:0] reg_at(input int i);
    return regs_o[i*8 +: 8];
  endfunction

  initial begin
    wt(5);
    check("R1 sda_oe after reset", {7'd0, sda_oe}, 8'h00);
    check("R1 regs zero", {7'd0, regs_o == '0}, 8'h01);
    rst_n = 1'b1; wt(10);

    // R3: pointer 2, four sequential writes
    bus_start; send_byte(AW1, 1, "R2 addr ack");
    send_byte(8'h02, 1, "R3 ptr ack");
    send_byte(8'hA5, 1, "R3 data"); send_byte(8'h3C, 1, "R3 data");
    send_byte(8'h81, 1, "R3 data"); send_byte(8'h5E, 1, "R3 data");
    bus_stop;
    check("R3 reg2", reg_at(2), 8'hA5); check("R3 reg3", reg_at(3), 8'h3C);
    check("R3 reg4", reg_at(4), 8'h81); check("R3 reg5", reg_at(5), 8'h5E);

    // R4/R5: set pointer, stop, read three with final NACK
    bus_start; send_byte(AW1, 1, "R4 addr"); send_byte(8'h02, 1, "R4 ptr"); bus_stop;
    bus_start; send_byte(AR1, 1, "R4 read addr");
    recv_byte(8'hA5, 1, "R4 rd0"); recv_byte(8'h3C, 1, "R4 rd1");
    recv_byte(8'h81, 0, "R5 rd2 nack");
    wt(HP);
    check("R5 released after nack", {7'd0, sda_oe}, 8'h00);
    bus_stop;
    // R4: pointer survives stop and continues at 5
    bus_start; send_byte(AR1, 1, "R4 read addr"); recv_byte(8'h5E, 0, "R4 kept ptr"); bus_stop;

    // R2: mismatch ignored, then addr_sel=0 selects other address
    bus_start; send_byte(AW0, 0, "R2 mismatch nack");
    send_byte(8'h00, 0, "R2 ignored ptr"); send_byte(8'hFF, 0, "R2 ignored data");
    bus_stop;
    check("R2 reg0 untouched", reg_at(0), 8'h00);
    addr_sel = 1'b0; wt(4);
    bus_start; send_byte(AW0, 1, "R2 sel0 ack"); send_byte(8'h01, 1, "R2 ptr");
    send_byte(8'h6D, 1, "R2 data"); bus_stop;
    check("R2 reg1 via sel0", reg_at(1), 8'h6D);
    addr_sel = 1'b1; wt(4);

    // R6: repeated starts, including one in mid-byte
    bus_start; send_byte(AW1, 1, "R6 addr"); send_byte(8'h07, 1, "R6 ptr");
    send_byte(8'h11, 1, "R6 data");
    bus_start; send_byte(AW1, 1, "R6 rs addr"); send_byte(8'h07, 1, "R6 rs ptr");
    bus_start; send_byte(AR1, 1, "R6 rs read addr"); recv_byte(8'h11, 0, "R6 rs read");
    bus_stop;
    bus_start; send_byte(AW1, 1, "R6 addr"); send_byte(8'h09, 1, "R6 ptr");
    send_bits(8'hF0, 3, 1'b0);
    bus_start; send_byte(AW1, 1, "R6 mid-byte restart"); send_byte(8'h09, 1, "R6 ptr");
    send_byte(8'h22, 1, "R6 data"); bus_stop;
    check("R6 reg9", reg_at(9), 8'h22);
    check("R6 reg7", reg_at(7), 8'h11);

    // R7: reserved index
    bus_start; send_byte(AW1, 1, "R7 addr"); send_byte(8'h0E, 1, "R7 ptr");
    send_byte(8'h44, 1, "R7 reg14"); send_byte(8'h55, 0, "R7 rsvd write nack");
    bus_stop;
    check("R7 reg14", reg_at(14), 8'h44); check("R7 reg15", reg_at(15), 8'h00);
    bus_start; send_byte(AW1, 1, "R7 addr"); send_byte(8'h0F, 1, "R7 ptr"); bus_stop;
    bus_start; send_byte(AR1, 0, "R7 rsvd read nack"); bus_stop;
    bus_start; send_byte(AW1, 1, "R7 addr"); send_byte(8'h0E, 1, "R7 ptr"); bus_stop;
    bus_start; send_byte(AR1, 1, "R7 read addr"); recv_byte(8'h44, 1, "R7 rd14");
    recv_byte(8'hFF, 0, "R7 rsvd read released"); bus_stop;

    // R8: out of range writes, wrap, reads
    bus_start; send_byte(AW1, 1, "R8 addr"); send_byte(8'hFE, 1, "R8 ptr");
    send_byte(8'h99, 1, "R8 drop ack"); send_byte(8'h77, 1, "R8 drop ack");
    send_byte(8'h66, 1, "R8 wrap write"); bus_stop;
    check("R8 reg0 after wrap", reg_at(0), 8'h66);
    check("R8 reg14 untouched", reg_at(14), 8'h44);
    bus_start; send_byte(AW1, 1, "R8 addr"); send_byte(8'hFF, 1, "R8 ptr"); bus_stop;
    bus_start; send_byte(AR1, 1, "R8 read addr"); recv_byte(8'h00, 1, "R8 out of range read");
    recv_byte(8'h66, 0, "R8 wrapped read"); bus_stop;

    // R9: short SCL glitches within every bit period
    bus_start; send_byte(AW1, 1, "R9 addr"); send_byte(8'h0A, 1, "R9 ptr");
    send_byte(8'hC3, 1, "R9 glitched data", 1'b1); bus_stop;
    check("R9 reg10", reg_at(10), 8'hC3);

    wt(20);
    check("R10 sda_oe steady while scl high", r10_viol[7:0], 8'h00);
    check("R3 scoreboard drained", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule